// File: doc/BRIEF.md
# Masked Hit Multiplicity Encoder

This block sits behind the link receivers of a chamber trigger system. Every bunch-crossing clock, each link delivers a 16-bit word of trigger bits that is already aligned to the system clock. Per link, the block drops any bit whose enable-mask bit is cleared. It counts the remaining set bits into a 4-bit multiplicity that saturates at 15. It then flags the chamber as hit when that multiplicity is strictly greater than a shared programmable threshold. A downstream majority stage uses the multiplicity and the hit flag.

Twelve links are handled: ten in service and two spares. Each link can be switched off, and the spares come out of reset switched off. A simple write/read configuration port holds the masks, the threshold and the link enables. It also exposes one saturating event scaler per link, which counts the clock cycles in which that link's hit flag is raised. Writing to a scaler's address clears it.

Top module: `hit_mult_enc`

## Requirements
- R1: After reset every multiplicity output is 0, every hit flag is low, every mask reads 0xFFFF, the threshold reads 0 and the link-enable register reads 0x3FF (links 0 to 9 on, spares 10 and 11 off).
- R2: A word presented on link n before clock edge k appears as that link's multiplicity and hit flag right after edge k+1 (two-cycle latency), and a new word is accepted every cycle.
- R3: Bit i of the mask register at address n (bits 15:0) enables trigger bit i of link n; a trigger bit whose mask bit is 0 never contributes to the count.
- R4: The multiplicity equals the number of enabled set bits, saturated at 15 (all 16 enabled bits set gives 15).
- R5: The hit flag of link n is 1 exactly when its multiplicity is strictly greater than the threshold held in bits 3:0 of address 16.
- R6: Bit n of the link-enable register at address 17 switches link n on; a switched-off link outputs multiplicity 0 and hit flag 0 whatever its input.
- R7: The scaler of link n, read at address 32+n, increases by one for every clock cycle in which hit_o[n] is 1.
- R8: A scaler that reaches its all-ones value stays there and does not wrap.
- R9: A write of any data to address 32+n clears scaler n to 0.
- R10: Reads are combinational on cfg_rdata: addresses 0 to 11 return the masks, 16 the threshold, 17 the link enables, 32 to 43 the scalers (zero-extended), and any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (one cycle per bunch crossing) |
| rst_n | input | 1 | Synchronous active-low reset |
| tbit_i | input | 192 | Synchronised trigger bits, link n in bits 16n+15:16n |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_addr |
| mult_o | output | 48 | Multiplicity per link, link n in bits 4n+3:4n |
| hit_o | output | 12 | Hit flag per link |

## Verification
The count path is driven with streams of new random words every cycle, at several densities (sparse AND-ed words, dense OR-ed words, all-ones and all-zero words). Each stream runs under random masks, thresholds and link enables. This separates the off-by-one latency, mask and threshold comparison faults from each other. Directed all-ones words on a full mask tell apart saturation at 15 from wrapping to 0. A half mask under all-ones input shows that masked bits are dropped. A popcount that equals the threshold exposes a greater-or-equal comparison. Held hit patterns of known length check the scaler count, clearing and saturation. The bench builds the scaler 8 bits wide so that saturation is reached quickly.

// File: rtl/hme_pkg.sv
// Shared constants for the masked hit multiplicity encoder.
// Assumes at most 16 links and link words of at most 32 bits.
package hme_pkg;
    localparam int CFG_ADDR_W = 6;
    localparam int CFG_DATA_W = 32;
    localparam logic [CFG_ADDR_W-1:0] ADDR_THRESH      = 6'd16;
    localparam logic [CFG_ADDR_W-1:0] ADDR_LINK_EN     = 6'd17;
    localparam logic [CFG_ADDR_W-1:0] ADDR_SCALER_BASE = 6'd32;
endpackage

// File: rtl/hme_link.sv
// One link's count path: stage 1 registers the masked and enabled word,
// stage 2 registers the saturated popcount and the threshold flag.
// Assumes LINK_BITS >= 2**MULT_W - 1, so all-ones saturates.
module hme_link #(
    parameter int LINK_BITS = 16,
    parameter int MULT_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LINK_BITS-1:0] tbit,
    input  logic [LINK_BITS-1:0] mask,
    input  logic                 link_en,
    input  logic [MULT_W-1:0]    thresh,
    output logic [MULT_W-1:0]    mult,
    output logic                 hit
);
    localparam int SUM_W    = $clog2(LINK_BITS + 1);
    localparam int MULT_MAX = (1 << MULT_W) - 1;

    logic [LINK_BITS-1:0] s1_q;
    logic [SUM_W-1:0]     sum_c;
    logic [MULT_W-1:0]    sat_c;
    logic [MULT_W-1:0]    mult_q;
    logic                 hit_q;

    // Stage 1: keep only enabled bits of an enabled link.
    always_ff @(posedge clk) begin
        if (!rst_n)       s1_q <= '0;
        else if (link_en) s1_q <= tbit & mask;
        else              s1_q <= '0;
    end

    // Count the surviving bits and clamp to the multiplicity range.
    always_comb begin
        sum_c = '0;
        for (int i = 0; i < LINK_BITS; i++) sum_c = sum_c + SUM_W'(s1_q[i]);
        if (int'(sum_c) > MULT_MAX) sat_c = MULT_W'(MULT_MAX);
        else                        sat_c = MULT_W'(sum_c);
    end

    // Stage 2: register multiplicity and strict greater-than flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mult_q <= '0;
            hit_q  <= 1'b0;
        end else begin
            mult_q <= sat_c;
            hit_q  <= (sat_c > thresh);
        end
    end

    assign mult = mult_q;
    assign hit  = hit_q;

    assert_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (&s1_q) |=> (mult_q == MULT_W'(MULT_MAX)));
    assert_hit_rule_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q == (mult_q > $past(thresh)));
    assert_link_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(link_en, 2) |-> (mult_q == '0 && !hit_q));
endmodule

// File: rtl/hme_scaler.sv
// Saturating event counter with a synchronous clear that has priority.
module hme_scaler #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_q;

    // Count events, hold at all ones, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)      cnt_q <= '0;
        else if (inc && !(&cnt_q)) cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));
    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((&cnt_q) && !clear) |=> (&cnt_q));
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !inc) |=> $stable(cnt_q));
endmodule

// File: rtl/hme_regs.sv
// Configuration store and read multiplexer: per-link masks, shared
// threshold, link enables, scaler readback and scaler clear strobes.
// Assumes NUM_LINKS <= 16, LINK_BITS <= 32 and SCALER_W <= 32.
module hme_regs
    import hme_pkg::*;
#(
    parameter int                 NUM_LINKS = 12,
    parameter int                 LINK_BITS = 16,
    parameter int                 MULT_W    = 4,
    parameter int                 SCALER_W  = 32,
    parameter logic [NUM_LINKS-1:0] EN_RESET = '1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_we,
    input  logic [CFG_ADDR_W-1:0]           cfg_addr,
    input  logic [CFG_DATA_W-1:0]           cfg_wdata,
    input  logic [NUM_LINKS*SCALER_W-1:0]   scaler_flat,
    output logic [NUM_LINKS*LINK_BITS-1:0]  mask_flat,
    output logic [MULT_W-1:0]               thresh,
    output logic [NUM_LINKS-1:0]            link_en,
    output logic [NUM_LINKS-1:0]            scaler_clr,
    output logic [CFG_DATA_W-1:0]           cfg_rdata
);
    logic [LINK_BITS-1:0] mask_q [NUM_LINKS];
    logic [MULT_W-1:0]    thresh_q;
    logic [NUM_LINKS-1:0] en_q;

    // Register writes; masks reset to all enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NUM_LINKS; n++) mask_q[n] <= '1;
            thresh_q <= '0;
            en_q     <= EN_RESET;
        end else if (cfg_we) begin
            for (int n = 0; n < NUM_LINKS; n++)
                if (cfg_addr == CFG_ADDR_W'(n)) mask_q[n] <= cfg_wdata[LINK_BITS-1:0];
            if (cfg_addr == ADDR_THRESH)  thresh_q <= cfg_wdata[MULT_W-1:0];
            if (cfg_addr == ADDR_LINK_EN) en_q     <= cfg_wdata[NUM_LINKS-1:0];
        end
    end

    // Scaler clear strobes from writes to the scaler window.
    always_comb begin
        for (int n = 0; n < NUM_LINKS; n++)
            scaler_clr[n] = cfg_we && (cfg_addr == ADDR_SCALER_BASE + CFG_ADDR_W'(n));
    end

    // Combinational read multiplexer; unmapped addresses read zero.
    always_comb begin
        cfg_rdata = '0;
        for (int n = 0; n < NUM_LINKS; n++) begin
            if (cfg_addr == CFG_ADDR_W'(n))
                cfg_rdata[LINK_BITS-1:0] = mask_q[n];
            if (cfg_addr == ADDR_SCALER_BASE + CFG_ADDR_W'(n))
                cfg_rdata[SCALER_W-1:0] = scaler_flat[n*SCALER_W +: SCALER_W];
        end
        if (cfg_addr == ADDR_THRESH)  cfg_rdata[MULT_W-1:0]    = thresh_q;
        if (cfg_addr == ADDR_LINK_EN) cfg_rdata[NUM_LINKS-1:0] = en_q;
    end

    // Flatten the mask array for the link instances.
    always_comb begin
        for (int n = 0; n < NUM_LINKS; n++) mask_flat[n*LINK_BITS +: LINK_BITS] = mask_q[n];
    end

    assign thresh  = thresh_q;
    assign link_en = en_q;

    assert_thresh_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == ADDR_THRESH) |=> (thresh_q == $past(cfg_wdata[MULT_W-1:0])));
    assert_clr_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(scaler_clr));
endmodule

// File: rtl/hit_mult_enc.sv
// Top level: NUM_LINKS count paths, one scaler per link and the
// configuration store. The last NUM_SPARE links reset to switched off.
// Assumes the trigger words are already synchronous to clk.
module hit_mult_enc
    import hme_pkg::*;
#(
    parameter int NUM_LINKS = 12,
    parameter int NUM_SPARE = 2,
    parameter int LINK_BITS = 16,
    parameter int MULT_W    = 4,
    parameter int SCALER_W  = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_LINKS*LINK_BITS-1:0] tbit_i,
    input  logic                           cfg_we,
    input  logic [CFG_ADDR_W-1:0]          cfg_addr,
    input  logic [CFG_DATA_W-1:0]          cfg_wdata,
    output logic [CFG_DATA_W-1:0]          cfg_rdata,
    output logic [NUM_LINKS*MULT_W-1:0]    mult_o,
    output logic [NUM_LINKS-1:0]           hit_o
);
    localparam int NUM_ACTIVE = NUM_LINKS - NUM_SPARE;
    localparam logic [NUM_LINKS-1:0] EN_RESET =
        NUM_LINKS'((64'd1 << NUM_ACTIVE) - 64'd1);

    logic [NUM_LINKS*LINK_BITS-1:0] mask_flat;
    logic [MULT_W-1:0]              thresh;
    logic [NUM_LINKS-1:0]           link_en;
    logic [NUM_LINKS-1:0]           scaler_clr;
    logic [NUM_LINKS*SCALER_W-1:0]  scaler_flat;

    hme_regs #(
        .NUM_LINKS(NUM_LINKS), .LINK_BITS(LINK_BITS), .MULT_W(MULT_W),
        .SCALER_W(SCALER_W), .EN_RESET(EN_RESET)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .scaler_flat(scaler_flat), .mask_flat(mask_flat),
        .thresh(thresh), .link_en(link_en), .scaler_clr(scaler_clr),
        .cfg_rdata(cfg_rdata)
    );

    for (genvar n = 0; n < NUM_LINKS; n++) begin : g_link
        hme_link #(.LINK_BITS(LINK_BITS), .MULT_W(MULT_W)) u_link (
            .clk(clk), .rst_n(rst_n),
            .tbit(tbit_i[n*LINK_BITS +: LINK_BITS]),
            .mask(mask_flat[n*LINK_BITS +: LINK_BITS]),
            .link_en(link_en[n]), .thresh(thresh),
            .mult(mult_o[n*MULT_W +: MULT_W]), .hit(hit_o[n])
        );
        hme_scaler #(.W(SCALER_W)) u_scaler (
            .clk(clk), .rst_n(rst_n), .clear(scaler_clr[n]), .inc(hit_o[n]),
            .count(scaler_flat[n*SCALER_W +: SCALER_W])
        );
    end
endmodule

// File: tb/hit_mult_enc_test.sv
// Bench: random streams under random configuration plus directed corners.
module hit_mult_enc_test;
    localparam int NL = 12;
    localparam int LB = 16;
    localparam int SW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NL*LB-1:0] tbit_i = '0;
    logic            cfg_we = 1'b0;
    logic [5:0]      cfg_addr = '0;
    logic [31:0]     cfg_wdata = '0;
    logic [31:0]     cfg_rdata;
    logic [NL*4-1:0] mult_o;
    logic [NL-1:0]   hit_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    logic [15:0] mask_m [NL];
    int          thr_m;
    logic [NL-1:0] en_m;

    hit_mult_enc #(.SCALER_W(SW)) uut (
        .clk(clk), .rst_n(rst_n), .tbit_i(tbit_i), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mult_o(mult_o), .hit_o(hit_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    function automatic int exp_mult(input int n, input logic [15:0] w);
        int c;
        if (!en_m[n]) return 0;
        c = $countones(w & mask_m[n]);
        return (c > 15) ? 15 : c;
    endfunction

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output int v);
        cfg_addr = a;
        #1;
        v = int'(cfg_rdata);
    endtask

    task automatic idle(input int c);
        for (int i = 0; i < c; i++) @(negedge clk);
    endtask

    task automatic check_links(input string tag, input logic [15:0] w [NL]);
        for (int n = 0; n < NL; n++) begin
            chk($sformatf("%s mult link %0d", tag, n), int'(mult_o[n*4 +: 4]), exp_mult(n, w[n]));
            chk($sformatf("R5 hit link %0d", n), int'(hit_o[n]), (exp_mult(n, w[n]) > thr_m) ? 1 : 0);
        end
    endtask

    // Hold one word on every link, then check after the pipeline delay.
    task automatic apply_all(input string tag, input logic [15:0] w [NL]);
        @(negedge clk);
        for (int n = 0; n < NL; n++) tbit_i[n*LB +: LB] = w[n];
        idle(2);
        check_links(tag, w);
    endtask

    // New word every cycle; output at negedge t checks word of negedge t-2 (R2).
    task automatic stream(input int ncyc, input int kind);
        logic [15:0] h1 [NL];
        logic [15:0] h2 [NL];
        logic [15:0] nw;
        for (int t = 0; t < ncyc; t++) begin
            @(negedge clk);
            if (t >= 2) check_links("R2 R3 R4", h2);
            for (int n = 0; n < NL; n++) begin
                case (kind == 0 ? int'($urandom % 4) : kind)
                    0: nw = 16'($urandom);
                    1: nw = 16'($urandom & $urandom & $urandom);
                    2: nw = 16'($urandom | $urandom);
                    default: nw = ($urandom % 2) ? 16'hFFFF : 16'h0000;
                endcase
                h2[n] = h1[n];
                h1[n] = nw;
                tbit_i[n*LB +: LB] = nw;
            end
        end
    endtask

    task automatic zero_inputs();
        @(negedge clk);
        tbit_i = '0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int v;
        logic [15:0] w [NL];
        void'($urandom(32'h0005EED5));
        for (int n = 0; n < NL; n++) mask_m[n] = 16'hFFFF;
        thr_m = 0;
        en_m  = 12'h3FF;

        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 mult after reset", int'(mult_o), 0);
        chk("R1 hit after reset", int'(hit_o), 0);
        rd(6'd0, v);  chk("R1 mask0 reset", v, 16'hFFFF);
        rd(6'd11, v); chk("R1 mask11 reset", v, 16'hFFFF);
        rd(6'd16, v); chk("R1 threshold reset", v, 0);
        rd(6'd17, v); chk("R1 link enable reset", v, 12'h3FF);
        // R10 unmapped and scaler window reads
        rd(6'd20, v); chk("R10 unmapped read", v, 0);
        rd(6'd63, v); chk("R10 unmapped read 63", v, 0);
        rd(6'd33, v); chk("R10 scaler1 after reset", v, 0);

        // R4 saturation with all ones; R6 spares off at reset
        for (int n = 0; n < NL; n++) w[n] = 16'hFFFF;
        apply_all("R4 R6 all ones", w);
        chk("R4 link0 saturates", int'(mult_o[3:0]), 15);
        chk("R6 spare link10 off", int'(mult_o[43:40]), 0);

        // R3 half mask on link 2, R6 link 3 switched off, spares on
        wr(6'd2, 32'h0000_00FF); mask_m[2] = 16'h00FF;
        wr(6'd17, 32'h0000_0FF7); en_m = 12'hFF7;
        rd(6'd2, v); chk("R10 mask2 readback", v, 16'h00FF);
        apply_all("R3 R6 masked", w);
        chk("R3 link2 half mask", int'(mult_o[11:8]), 8);
        chk("R6 link3 disabled mult", int'(mult_o[15:12]), 0);
        chk("R6 link3 disabled hit", int'(hit_o[3]), 0);

        // R5 boundary: count equal to threshold is not a hit
        wr(6'd16, 32'h0000_0008); thr_m = 8;
        apply_all("R5 equal", w);
        chk("R5 link2 count==thr no hit", int'(hit_o[2]), 0);
        chk("R5 link0 count>thr hit", int'(hit_o[0]), 1);

        // Random configurations with random streams (R2 R3 R4 R5 R6)
        for (int it = 0; it < 10; it++) begin
            for (int n = 0; n < NL; n++) begin
                mask_m[n] = (it % 3 == 0) ? 16'hFFFF : 16'($urandom);
                wr(6'(n), {16'h0, mask_m[n]});
            end
            thr_m = int'($urandom % 16);
            wr(6'd16, 32'(thr_m));
            en_m = 12'($urandom);
            wr(6'd17, {20'h0, en_m});
            rd(6'd16, v); chk("R10 threshold readback", v, thr_m);
            rd(6'd17, v); chk("R10 enable readback", v, int'(en_m));
            stream(150, it % 5 == 4 ? 3 : (it % 5));
        end

        // Scalers: R7 counting, R9 clear, R8 saturation
        for (int n = 0; n < NL; n++) begin
            mask_m[n] = 16'hFFFF;
            wr(6'(n), 32'h0000_FFFF);
        end
        en_m = 12'hFFF; wr(6'd17, 32'h0000_0FFF);
        thr_m = 5; wr(6'd16, 32'd5);
        zero_inputs(); idle(3);
        wr(6'd36, 32'hDEAD_BEEF);
        wr(6'd37, 32'h0);
        rd(6'd36, v); chk("R9 scaler4 cleared", v, 0);
        @(negedge clk);
        tbit_i[4*LB +: LB] = 16'h00FF;  // 8 > 5: hit
        tbit_i[5*LB +: LB] = 16'h001F;  // 5 == 5: no hit
        idle(37);
        tbit_i = '0;
        idle(4);
        rd(6'd36, v); chk("R7 scaler4 counts 37 hits", v, 37);
        rd(6'd37, v); chk("R7 scaler5 no hits", v, 0);
        wr(6'd36, 32'h0);
        rd(6'd36, v); chk("R9 scaler4 cleared after count", v, 0);

        wr(6'd32, 32'h0);
        @(negedge clk);
        tbit_i[0 +: LB] = 16'hFFFF;
        idle(300);
        tbit_i = '0;
        idle(4);
        rd(6'd32, v); chk("R8 scaler0 saturates", v, 255);
        wr(6'd32, 32'h0);
        rd(6'd32, v); chk("R9 scaler0 clear from full", v, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule